// File: doc/BRIEF.md
# Memory Pattern Fill Engine

This block writes one 64-bit pattern over and over across a contiguous region of memory. Software programs a destination start address, a length in bytes and the two 32-bit halves of the pattern through a small word-addressed register port. It then writes the start bit. If the settings are legal, the engine emits one 64-bit write beat per accepted handshake on a valid/ready write port, stepping the address by eight bytes each time. When the last beat is taken, it drops back to idle and pulses `done` for one cycle.

Settings are checked at the moment the start bit is written. A length outside the allowed range, a length that is not a whole number of beats, or a start address that is not beat-aligned raises an error flag, and no write is issued. While a fill is running, the engine ignores every register write, including a second start. The pattern halves belong to the unit as a whole. The running fill reads them directly, so a running fill always sees the values that were present at launch.

Top module: `mfill_engine`

## Requirements
- R1: After reset, `wr_valid` and `done` are 0, and every register reads 0. This includes the status word at offset 0, whose bit 0 is busy and bit 1 is error.
- R2: Register offsets on `reg_addr` are: 0 control/status, 1 destination address, 2 length in bytes, 3 low pattern word, 4 high pattern word. While the engine is idle, offsets 1 to 4 read back the last value written to them.
- R3: Writing offset 0 with bit 0 set, while idle and with legal settings, starts a fill. In the cycle after that write, `wr_valid` is 1 and status bit 0 (busy) reads 1. A write to offset 0 with bit 0 clear starts nothing.
- R4: A start with a length below MIN_BYTES or above MAX_BYTES issues no beat, sets status bit 1 (error) and leaves busy at 0. Lengths equal to MIN_BYTES or to MAX_BYTES are accepted.
- R5: A start with a destination whose three low bits are not zero, or a length whose three low bits are not zero, is rejected in the same way as R4. A later successful start clears the error bit. Every issued address has its three low bits at zero.
- R6: A fill of L bytes issues exactly L/8 accepted beats. Beat i carries address dest+8*i and data {high word, low word}, with the high word in bits 63:32.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R8: In the cycle after the last beat is accepted, `done` is 1 for exactly one cycle, `wr_valid` is 0, and status bit 0 reads 0.
- R9: While busy, writes to offsets 1 to 4 and start writes are ignored. Readback is unchanged, and the running fill keeps its original address sequence, pattern and beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted when high with valid |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_data | output | 64 | Pattern data of the beat |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench sweeps every legal length from the minimum up to twice the minimum, at two destinations, with and without random backpressure. It also runs one fill at exactly the maximum length. The length sweep catches an off-by-one in the beat count: such a design would end one beat early or late, or would pulse `done` with the count wrong. The backpressure runs would expose a design that moves its address or data while `ready` is low.

The bench probes rejected starts one step below the minimum, one step above the maximum, at zero length and with misaligned addresses or lengths. A design with a loose range or alignment check would issue beats there. The bench also rewrites every register and the start bit in the middle of a fill. A design without the busy lockout would show changed readback, or beats carrying the new pattern or address.

// File: rtl/mfill_pkg.sv
// Package: shared register offsets, status bit positions and widths for the
// pattern fill engine. Assumes a 32-bit register port.
package mfill_pkg;
    localparam int REG_W      = 32;
    localparam int REG_AW     = 3;
    localparam int PAT_W      = 64;
    localparam int START_BIT  = 0;
    localparam int ST_BUSY    = 0;
    localparam int ST_ERR     = 1;

    typedef enum logic [REG_AW-1:0] {
        OFS_CTRL = 3'd0,
        OFS_DEST = 3'd1,
        OFS_LEN  = 3'd2,
        OFS_PLO  = 3'd3,
        OFS_PHI  = 3'd4
    } reg_ofs_e;
endpackage

// File: rtl/mfill_sizechk.sv
// Module: legality check of the programmed fill settings.
// Checks that the length lies within [MIN_BYTES, MAX_BYTES], that the length is
// a whole number of beats, and that the start address is beat-aligned.
// Assumes BEAT_BYTES is a power of two of at least 2.
module mfill_sizechk #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int MIN_BYTES  = 128,
    parameter int MAX_BYTES  = 16777216
) (
    input  logic [ADDR_W-1:0]             len,
    input  logic [$clog2(BEAT_BYTES)-1:0] dest_lsb,
    output logic                          ok
);
    localparam int ALIGN_W = $clog2(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] MIN_V = ADDR_W'(MIN_BYTES);
    localparam logic [ADDR_W-1:0] MAX_V = ADDR_W'(MAX_BYTES);

    logic in_range;
    logic len_whole;
    logic dest_even;

    // Range, granularity and alignment tests combined into one verdict.
    always_comb begin
        in_range  = (len >= MIN_V) && (len <= MAX_V);
        len_whole = (len[ALIGN_W-1:0] == '0);
        dest_even = (dest_lsb == '0);
        ok        = in_range && len_whole && dest_even;
    end
endmodule

// File: rtl/mfill_regs.sv
// Module: register file of the fill engine.
// Holds the destination, length and the two pattern words, and decodes the
// start bit. Writes to the setting registers and start are dropped while the
// engine is busy. The launch output is a one-cycle pulse, raised only for a
// legal start. The error flag records the verdict of the latest start.
module mfill_regs
    import mfill_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int MIN_BYTES  = 128,
    parameter int MAX_BYTES  = 16777216
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    output logic [ADDR_W-1:0] dest_q,
    output logic [ADDR_W-1:0] len_q,
    output logic [PAT_W-1:0]  pattern,
    output logic              launch
);
    localparam int ALIGN_W = $clog2(BEAT_BYTES);

    logic [REG_W-1:0] plo_q;
    logic [REG_W-1:0] phi_q;
    logic             err_q;
    logic             start_req;
    logic             cfg_ok;
    logic             open_wr;

    mfill_sizechk #(
        .ADDR_W    (ADDR_W),
        .BEAT_BYTES(BEAT_BYTES),
        .MIN_BYTES (MIN_BYTES),
        .MAX_BYTES (MAX_BYTES)
    ) u_chk (
        .len     (len_q),
        .dest_lsb(dest_q[ALIGN_W-1:0]),
        .ok      (cfg_ok)
    );

    // Decode of writes that may act: only while idle.
    always_comb begin
        open_wr   = reg_we && !busy;
        start_req = open_wr && (reg_addr == OFS_CTRL) && reg_wdata[START_BIT];
        launch    = start_req && cfg_ok;
        pattern   = {phi_q, plo_q};
    end

    // Setting registers, updated only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
            len_q  <= '0;
            plo_q  <= '0;
            phi_q  <= '0;
        end else if (open_wr) begin
            case (reg_addr)
                OFS_DEST: dest_q <= ADDR_W'(reg_wdata);
                OFS_LEN:  len_q  <= ADDR_W'(reg_wdata);
                OFS_PLO:  plo_q  <= reg_wdata;
                OFS_PHI:  phi_q  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // Error flag: set by a rejected start, cleared by an accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (start_req) begin
            err_q <= !cfg_ok;
        end
    end

    // Read multiplexer over the register offsets.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[ST_BUSY] = busy;
                reg_rdata[ST_ERR]  = err_q;
            end
            OFS_DEST: reg_rdata = REG_W'(dest_q);
            OFS_LEN:  reg_rdata = REG_W'(len_q);
            OFS_PLO:  reg_rdata = plo_q;
            OFS_PHI:  reg_rdata = phi_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R9: settings do not move while a fill runs.
    assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dest_q) && $stable(len_q) && $stable(pattern));

    // R4 / R5: an illegal start raises the error flag and does not launch.
    assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !busy && reg_addr == OFS_CTRL && reg_wdata[START_BIT] && !cfg_ok)
        |=> err_q && !busy);

    // R5: an accepted start leaves the error flag clear.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !err_q && busy);
endmodule

// File: rtl/mfill_seq.sv
// Module: beat sequencer of the fill engine.
// On launch it loads the start address and the beat count. It then presents
// one beat at a time, advancing on each valid/ready handshake and holding
// steady under backpressure. It reads the pattern live, and assumes the
// register file keeps the pattern frozen while busy.
module mfill_seq
    import mfill_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] dest,
    input  logic [CNT_W-1:0]  beats,
    input  logic [PAT_W-1:0]  pattern,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PAT_W-1:0]  wr_data,
    output logic              done
);
    localparam int ALIGN_W = $clog2(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic              busy_q;
    logic              done_q;
    logic              fire;

    // Handshake and output drive.
    always_comb begin
        fire     = busy_q && wr_ready;
        wr_valid = busy_q;
        wr_addr  = addr_q;
        wr_data  = pattern;
        busy     = busy_q;
        done     = done_q;
    end

    // Address, remaining count and busy state per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
        end else if (launch) begin
            addr_q <= dest;
            left_q <= beats;
            busy_q <= 1'b1;
        end else if (fire) begin
            addr_q <= addr_q + STEP;
            left_q <= left_q - ONE;
            if (left_q == ONE) begin
                busy_q <= 1'b0;
            end
        end
    end

    // One-cycle completion pulse after the final handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= fire && (left_q == ONE);
        end
    end

    // R7: beat held while the sink stalls.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R6: consecutive beats of one fill are one beat apart.
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) + STEP));

    // R8: completion pulse lasts one cycle and follows a handshake.
    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid && $past(wr_valid && wr_ready));

    // R5: issued addresses are beat-aligned.
    assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[ALIGN_W-1:0] == '0));
endmodule

// File: rtl/mfill_engine.sv
// Module: top of the memory pattern fill engine.
// Joins the register file, which holds the settings, checks them and raises
// launch, to the beat sequencer, which drives the write port. Assumes the
// sink accepts writes at any address it is given.
module mfill_engine
    import mfill_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int MIN_BYTES  = 128,
    parameter int MAX_BYTES  = 16777216
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    output logic              done
);
    localparam int ALIGN_W = $clog2(BEAT_BYTES);
    localparam int CNT_W   = $clog2(MAX_BYTES / BEAT_BYTES + 1);

    logic [ADDR_W-1:0] dest_q;
    logic [ADDR_W-1:0] len_q;
    logic [PAT_W-1:0]  pattern;
    logic              launch;
    logic              busy;
    logic [CNT_W-1:0]  beats;

    // Length in bytes converted to a beat count.
    always_comb begin
        beats = len_q[ALIGN_W +: CNT_W];
    end

    mfill_regs #(
        .ADDR_W    (ADDR_W),
        .BEAT_BYTES(BEAT_BYTES),
        .MIN_BYTES (MIN_BYTES),
        .MAX_BYTES (MAX_BYTES)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy     (busy),
        .dest_q   (dest_q),
        .len_q    (len_q),
        .pattern  (pattern),
        .launch   (launch)
    );

    mfill_seq #(
        .ADDR_W    (ADDR_W),
        .BEAT_BYTES(BEAT_BYTES),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .dest    (dest_q),
        .beats   (beats),
        .pattern (pattern),
        .busy    (busy),
        .wr_valid(wr_valid),
        .wr_ready(wr_ready),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done    (done)
    );
endmodule

// File: tb/sim_mfill_engine.sv
// Bench: sweeps legal lengths, boundary rejects and mid-fill lockout on a
// small configuration (MAX_BYTES = 1024), with expected beats computed here.
module sim_mfill_engine;
    localparam int MINB = 128;
    localparam int MAXB = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    mfill_engine #(.ADDR_W(32), .BEAT_BYTES(8), .MIN_BYTES(MINB), .MAX_BYTES(MAXB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor state
    bit          mon_on = 1'b0;
    bit          stall_mode = 1'b0;
    logic [31:0] exp_addr;
    logic [63:0] exp_pat;
    int          beats_seen;
    bit          was_stall = 1'b0;
    logic [31:0] prev_addr;
    logic [63:0] prev_data;
    logic [7:0]  lfsr = 8'h5B;

    // Ready driver, changes away from the sampling edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wr_ready = stall_mode ? lfsr[0] : 1'b1;
    end

    // Beat monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_on) begin
                if (was_stall) begin
                    chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data,
                        "R7 hold under stall", {32'd0, wr_addr}, {32'd0, prev_addr});
                end
                if (wr_valid && wr_ready) begin
                    chk(wr_addr == exp_addr, "R6 beat address", wr_addr, exp_addr);
                    chk(wr_data == exp_pat, "R6 beat data", wr_data, exp_pat);
                    exp_addr = exp_addr + 32'd8;
                    beats_seen++;
                end
                was_stall = wr_valid && !wr_ready;
                prev_addr = wr_addr;
                prev_data = wr_data;
            end else begin
                was_stall = 1'b0;
            end
        end
    end

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_fill(input logic [31:0] dest, input logic [31:0] len,
                            input logic [31:0] plo, input logic [31:0] phi,
                            input bit stall, input bit poke);
        logic [31:0] rd;
        int          cyc;
        stall_mode = stall;
        wreg(3'd1, dest); wreg(3'd2, len); wreg(3'd3, plo); wreg(3'd4, phi);
        exp_addr = dest; exp_pat = {phi, plo}; beats_seen = 0; mon_on = 1'b1;
        wreg(3'd0, 32'd1);
        rreg(3'd0, rd);
        chk(rd[1:0] == 2'b01, "R3 busy after start, R5 error clear", rd[1:0], 2'b01);
        chk(wr_valid == 1'b1, "R3 valid after start", wr_valid, 1);
        if (poke) begin
            wreg(3'd1, dest + 32'h100); wreg(3'd2, len + 32'd8);
            wreg(3'd3, ~plo); wreg(3'd4, ~phi); wreg(3'd0, 32'd1);
            rreg(3'd1, rd); chk(rd == dest, "R9 dest locked", rd, dest);
            rreg(3'd2, rd); chk(rd == len, "R9 length locked", rd, len);
            rreg(3'd3, rd); chk(rd == plo, "R9 low word locked", rd, plo);
            rreg(3'd4, rd); chk(rd == phi, "R9 high word locked", rd, phi);
        end
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R8 done seen", done, 1);
        chk(beats_seen == int'(len / 8), "R6 beat count", beats_seen, len / 8);
        chk(wr_valid == 1'b0, "R8 valid low at done", wr_valid, 0);
        rreg(3'd0, rd);
        chk(rd[0] == 1'b0, "R8 idle at done", rd[0], 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        mon_on = 1'b0;
        stall_mode = 1'b0;
    endtask

    task automatic reject(input logic [31:0] dest, input logic [31:0] len, input string tag);
        logic [31:0] rd;
        wreg(3'd1, dest); wreg(3'd2, len);
        wreg(3'd0, 32'd1);
        rreg(3'd0, rd);
        chk(rd[1:0] == 2'b10, tag, rd[1:0], 2'b10);
        for (int k = 0; k < 4; k++) begin
            chk(wr_valid == 1'b0, tag, wr_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(wr_valid == 1'b0 && done == 1'b0, "R1 outputs idle", {wr_valid, done}, 0);
        for (int a = 0; a < 5; a++) begin
            rreg(3'(a), rd);
            chk(rd == 32'd0, "R1 register zero", rd, 0);
        end
        // R2: readback while idle
        wreg(3'd1, 32'h1234_5678); wreg(3'd2, 32'hCAFE_0000);
        wreg(3'd3, 32'hDEAD_BEEF); wreg(3'd4, 32'h0BAD_F00D);
        rreg(3'd1, rd); chk(rd == 32'h1234_5678, "R2 dest readback", rd, 32'h1234_5678);
        rreg(3'd2, rd); chk(rd == 32'hCAFE_0000, "R2 length readback", rd, 32'hCAFE_0000);
        rreg(3'd3, rd); chk(rd == 32'hDEAD_BEEF, "R2 low readback", rd, 32'hDEAD_BEEF);
        rreg(3'd4, rd); chk(rd == 32'h0BAD_F00D, "R2 high readback", rd, 32'h0BAD_F00D);
        // R3: control write without start bit
        wreg(3'd1, 32'h0); wreg(3'd2, 32'd128);
        wreg(3'd0, 32'hFFFF_FFFE);
        rreg(3'd0, rd);
        chk(rd[1:0] == 2'b00 && wr_valid == 1'b0, "R3 no start when bit0 clear", rd[1:0], 0);
        // R4 / R5: rejected starts
        reject(32'h0, 32'd120, "R4 below minimum");
        reject(32'h0, 32'd0, "R4 zero length");
        reject(32'h0, MAXB + 8, "R4 above maximum");
        reject(32'h4, 32'd136, "R5 misaligned dest");
        reject(32'h0, 32'd132, "R5 partial beat length");
        // Main sweep, R3 R6 R7 R8
        for (int sz = MINB; sz <= 2 * MINB; sz += 8) begin
            for (int d = 0; d < 2; d++) begin
                for (int s = 0; s < 2; s++) begin
                    run_fill((d == 0) ? 32'h0 : 32'h4000_0000 + 32'(sz * 16), 32'(sz),
                             32'hA500_0000 ^ 32'(sz), ~(32'h5A00_0000 ^ 32'(sz * 3 + s)),
                             bit'(s), 1'b0);
                end
            end
        end
        // R4: maximum length accepted
        run_fill(32'h0000_8000, MAXB, 32'h0102_0304, 32'hF0E0_D0C0, 1'b1, 1'b0);
        // R5: error cleared by a good start after a reject
        reject(32'h3, 32'd128, "R5 misaligned dest again");
        run_fill(32'h10, 32'd128, 32'h1111_2222, 32'h3333_4444, 1'b0, 1'b0);
        // R9: lockout during a fill
        run_fill(32'h2000, 32'd256, 32'h7777_8888, 32'h9999_AAAA, 1'b1, 1'b1);
        rreg(3'd0, rd);
        chk(rd[0] == 1'b0 && wr_valid == 1'b0, "R9 no second fill from locked start", rd[0], 0);
        summary();
        $finish;
    end
endmodule